// File: doc/BRIEF.md
# Tape Controller Command and Status Unit

This block is the command front end of a controller that serves several tape drives. A processor-side agent addresses a drive by device number and either issues a command word or asks for the drive's status. A command can request a stop, which marks the drive for disconnection, or a start. A start latches an operation code, a BCD/binary mode bit and a 15-bit word count for that drive and hands the operation to a separate sequencer. One controller-wide busy interlock serialises all drives: while it is held, further starts are dropped without any trace.

The sequencer reports back through an end event that carries the status bits it produced. The unit merges those bits into the drive's latched status, clears the drive's busy bit, raises the drive's done flag and frees the controller. A separate release event frees the controller early without ending the drive, as a long rewind needs. A status request returns the latched bits merged with live drive conditions and clears that drive's done flag. Data movement and tape timing live elsewhere.

Top module: `tape_cmd_status`

## Requirements
- R1: Command word fields: word count in bits 14..0, operation code in bits 17..15 (0 read, 1 write, 2 reverse read, 3 write-and-erase, 4 skip forward, 5 write mark, 6 skip back, 7 rewind), BCD mode in bit 18, start in bit 19, stop in bit 20. An accepted start gives a one-cycle start_pulse in the cycle after the strobe, with start_unit, start_op, start_bcd and start_count holding the latched values.
- R2: A stop request sets disc_req only for the addressed drive and starts nothing; stop wins over a start in the same word. The flag clears when the drive is next started or ended.
- R3: A start while ctrl_busy is high is dropped: no pulse, and no change to any drive's status or done flag.
- R4: A start to a drive that is busy or not attached, with the controller free, sets that drive's operator-attention bit (bit 1) and its done flag, and starts nothing.
- R5: An accepted start sets the drive's status to busy (bit 5) alone, clears its done flag and sets ctrl_busy from the next cycle.
- R6: Status bits: terminate 0, operator attention 1, parity 2, late transfer 3, accept 4, busy 5, controller busy 6, write protect 9, beginning of tape 10, end of tape 11, offline 14, long block 15, fill word 16, tape mark 17. status_word is loaded in the cycle after status_stb and holds until the next status request.
- R7: A status read ORs in controller busy (bit 6) from ctrl_busy, offline (bit 14) from a low attach input, and write protect, beginning and end of tape (bits 9, 10, 11) from the live drive inputs.
- R8: A status read clears the addressed drive's done flag.
- R9: A device number below BASE_ADDR or at BASE_ADDR+NUM_UNITS or above reads as a zero status word and its commands have no effect.
- R10: An end event for a drive ORs seq_flags (except bits 5 and 6) into its status, clears its busy bit and disc_req, sets its done flag, and frees the controller if that drive holds it.
- R11: seq_release frees the controller without changing any drive's status or done flag.
- R12: After reset all drive status, done and disconnect flags, ctrl_busy, start_pulse and status_word are zero.
- R13: When an end event and a status read hit the same drive in one cycle, the done flag ends up set; the returned status is the state before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle command strobe |
| status_stb | input | 1 | One-cycle status request strobe |
| dev_addr | input | ADDR_W | Device number of the addressed drive |
| cmd_word | input | 24 | Command word |
| drive_attached | input | NUM_UNITS | Drive present and loaded, per drive |
| drive_wprot | input | NUM_UNITS | Live write-protect condition |
| drive_bot | input | NUM_UNITS | Live beginning-of-tape condition |
| drive_eot | input | NUM_UNITS | Live end-of-tape condition |
| seq_end | input | 1 | Sequencer end event |
| seq_unit | input | UNIT_W | Drive the end event refers to |
| seq_flags | input | 24 | Status bits produced by the sequencer |
| seq_release | input | 1 | Free the controller without ending a drive |
| status_word | output | 24 | Registered status returned on request |
| done | output | NUM_UNITS | Per-drive done flags |
| disc_req | output | NUM_UNITS | Per-drive disconnect request flags |
| ctrl_busy | output | 1 | Controller interlock held |
| start_pulse | output | 1 | One-cycle start hand-off to the sequencer |
| start_unit | output | UNIT_W | Drive that was started |
| start_op | output | 3 | Latched operation code |
| start_bcd | output | 1 | Latched BCD mode |
| start_count | output | 15 | Latched word count |

## Verification
The assertions take for granted that cmd_stb and status_stb never rise in the same cycle, and that the live drive inputs are stable across the edge that samples them; the stimulus only ever raises one of the two strobes and changes every input half a cycle away from the edge. End events may name any drive, busy or not, even a number beyond the drive count, and the per-drive properties are written so that such stray events do not break them. Random traffic covers addresses on both sides of the valid range, stop and start in one word, and release and end events landing on the same cycle as commands.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int STAT_W = 24;
  localparam int CMD_W  = 24;
  localparam int CNT_W  = 15;
  localparam int OP_W   = 3;

  // command word field positions
  localparam int CB_OP_LO = 15;
  localparam int CB_BCD   = 18;
  localparam int CB_START = 19;
  localparam int CB_STOP  = 20;

  // status word bit positions
  localparam int ST_TERM  = 0;
  localparam int ST_ATTN  = 1;
  localparam int ST_PAR   = 2;
  localparam int ST_LATE  = 3;
  localparam int ST_ACC   = 4;
  localparam int ST_BUSY  = 5;
  localparam int ST_CBUSY = 6;
  localparam int ST_WPROT = 9;
  localparam int ST_BOT   = 10;
  localparam int ST_EOT   = 11;
  localparam int ST_OFFL  = 14;
  localparam int ST_LONG  = 15;
  localparam int ST_FILL  = 16;
  localparam int ST_MARK  = 17;

  localparam logic [STAT_W-1:0] BUSY_ONLY = STAT_W'(1) << ST_BUSY;
  localparam logic [STAT_W-1:0] SEQ_MASK  =
    ~((STAT_W'(1) << ST_BUSY) | (STAT_W'(1) << ST_CBUSY));

  typedef enum logic [OP_W-1:0] {
    OP_READ, OP_WRITE, OP_RREAD, OP_WERASE,
    OP_SKIPF, OP_WMARK, OP_SKIPB, OP_REWIND
  } op_e;

  typedef struct packed {
    logic             stop;
    logic             start;
    logic             bcd;
    op_e              op;
    logic [CNT_W-1:0] count;
  } cmd_t;
endpackage

// File: rtl/tcs_cmd_decode.sv
module tcs_cmd_decode
  import tcs_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 24,
  parameter int NUM_UNITS = 6,
  parameter int UNIT_W    = 3
) (
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [20:0]       cmd_bits,
  output logic              addr_ok,
  output logic [UNIT_W-1:0] unit,
  output cmd_t              cmd
);
  localparam logic [ADDR_W:0] BASE_W = BASE_ADDR[ADDR_W:0];
  localparam logic [ADDR_W:0] NUM_W  = NUM_UNITS[ADDR_W:0];

  logic [ADDR_W:0] offset;

  always_comb begin
    offset  = {1'b0, dev_addr} - BASE_W;
    addr_ok = ({1'b0, dev_addr} >= BASE_W) && (offset < NUM_W);
    unit    = offset[UNIT_W-1:0];
  end

  always_comb begin
    cmd.stop  = cmd_bits[CB_STOP];
    cmd.start = cmd_bits[CB_START];
    cmd.bcd   = cmd_bits[CB_BCD];
    cmd.op    = op_e'(cmd_bits[CB_OP_LO +: OP_W]);
    cmd.count = cmd_bits[CNT_W-1:0];
  end
endmodule

// File: rtl/tcs_drive_slot.sv
module tcs_drive_slot
  import tcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_hit,
  input  logic              grant_hit,
  input  logic              refuse_hit,
  input  logic              read_hit,
  input  logic              end_hit,
  input  op_e               new_op,
  input  logic              new_bcd,
  input  logic [CNT_W-1:0]  new_count,
  input  logic [STAT_W-1:0] end_flags,
  output logic [STAT_W-1:0] stat_q,
  output op_e               op_q,
  output logic              bcd_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              disc_q,
  output logic              done_q,
  output logic              busy
);
  logic [STAT_W-1:0] stat_d;
  op_e               op_d;
  logic              bcd_d;
  logic [CNT_W-1:0]  count_d;
  logic              disc_d;
  logic              done_d;
  logic              slot_en;

  assign busy    = stat_q[ST_BUSY];
  assign slot_en = stop_hit | grant_hit | refuse_hit | read_hit | end_hit;

  // events applied in a fixed order; a later one overrides an earlier one
  always_comb begin
    stat_d  = stat_q;
    op_d    = op_q;
    bcd_d   = bcd_q;
    count_d = count_q;
    disc_d  = disc_q;
    done_d  = done_q;
    if (stop_hit) begin
      disc_d = 1'b1;
    end
    if (grant_hit) begin
      stat_d  = BUSY_ONLY;
      op_d    = new_op;
      bcd_d   = new_bcd;
      count_d = new_count;
      disc_d  = 1'b0;
      done_d  = 1'b0;
    end
    if (refuse_hit) begin
      stat_d[ST_ATTN] = 1'b1;
      done_d          = 1'b1;
    end
    if (read_hit) begin
      done_d = 1'b0;
    end
    if (end_hit) begin
      stat_d          = stat_d | (end_flags & SEQ_MASK);
      stat_d[ST_BUSY] = 1'b0;
      disc_d          = 1'b0;
      done_d          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      op_q    <= OP_READ;
      bcd_q   <= 1'b0;
      count_q <= '0;
      disc_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (slot_en) begin
      stat_q  <= stat_d;
      op_q    <= op_d;
      bcd_q   <= bcd_d;
      count_q <= count_d;
      disc_q  <= disc_d;
      done_q  <= done_d;
    end
  end

  AST_STOP_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !end_hit) |=> disc_q); // R2
  AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_hit && !end_hit) |=> (busy && !done_q && !disc_q)); // R5
  AST_REFUSE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_hit |=> (done_q && stat_q[ST_ATTN])); // R4
  AST_REFUSE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse_hit && !grant_hit) |=> $stable(count_q)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (read_hit && !end_hit && !refuse_hit) |=> !done_q); // R8
  AST_END_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |=> (done_q && !busy && !disc_q)); // R10
endmodule

// File: rtl/tcs_status_build.sv
module tcs_status_build
  import tcs_pkg::*;
#(
  parameter int NUM_UNITS = 6,
  parameter int UNIT_W    = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              stb,
  input  logic                              addr_ok,
  input  logic [UNIT_W-1:0]                 unit,
  input  logic [NUM_UNITS-1:0][STAT_W-1:0]  stat_all,
  input  logic                              ctrl_busy,
  input  logic [NUM_UNITS-1:0]              attached,
  input  logic [NUM_UNITS-1:0]              wprot,
  input  logic [NUM_UNITS-1:0]              bot,
  input  logic [NUM_UNITS-1:0]              eot,
  output logic [STAT_W-1:0]                 status_word
);
  logic [STAT_W-1:0] latched_sel;
  logic [STAT_W-1:0] live_bits;
  logic [STAT_W-1:0] status_d;

  always_comb begin
    latched_sel = '0;
    live_bits   = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (addr_ok && (unit == UNIT_W'(i))) begin
        latched_sel         = stat_all[i];
        live_bits[ST_OFFL]  = ~attached[i];
        live_bits[ST_WPROT] = wprot[i];
        live_bits[ST_BOT]   = bot[i];
        live_bits[ST_EOT]   = eot[i];
      end
    end
    live_bits[ST_CBUSY] = ctrl_busy;
    status_d = addr_ok ? (latched_sel | live_bits) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_word <= '0;
    end else if (stb) begin
      status_word <= status_d;
    end
  end

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !addr_ok) |=> (status_word == '0)); // R9
  AST_CBUSY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && addr_ok) |=> (status_word[ST_CBUSY] == $past(ctrl_busy))); // R7
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(status_word)); // R6
endmodule

// File: rtl/tape_cmd_status.sv
module tape_cmd_status
  import tcs_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 24,
  parameter int NUM_UNITS = 6,
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_stb,
  input  logic                 status_stb,
  input  logic [ADDR_W-1:0]    dev_addr,
  input  logic [CMD_W-1:0]     cmd_word,
  input  logic [NUM_UNITS-1:0] drive_attached,
  input  logic [NUM_UNITS-1:0] drive_wprot,
  input  logic [NUM_UNITS-1:0] drive_bot,
  input  logic [NUM_UNITS-1:0] drive_eot,
  input  logic                 seq_end,
  input  logic [UNIT_W-1:0]    seq_unit,
  input  logic [STAT_W-1:0]    seq_flags,
  input  logic                 seq_release,
  output logic [STAT_W-1:0]    status_word,
  output logic [NUM_UNITS-1:0] done,
  output logic [NUM_UNITS-1:0] disc_req,
  output logic                 ctrl_busy,
  output logic                 start_pulse,
  output logic [UNIT_W-1:0]    start_unit,
  output logic [OP_W-1:0]      start_op,
  output logic                 start_bcd,
  output logic [CNT_W-1:0]     start_count
);
  localparam logic [UNIT_W:0] NUM_U = NUM_UNITS[UNIT_W:0];

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  // decode
  logic              addr_ok;
  logic [UNIT_W-1:0] dec_unit;
  cmd_t              dec_cmd;

  tcs_cmd_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)
  ) u_decode (
    .dev_addr(dev_addr),
    .cmd_bits(cmd_word[20:0]),
    .addr_ok (addr_ok),
    .unit    (dec_unit),
    .cmd     (dec_cmd)
  );

  // controller interlock state
  logic              cbusy_q, cbusy_d;
  logic [UNIT_W-1:0] owner_q, owner_d;
  logic              pulse_q;
  logic              lock_en;

  logic start_try;
  logic stop_try;
  logic seq_ok;
  logic grant_any;

  logic [NUM_UNITS-1:0]              sel_vec;
  logic [NUM_UNITS-1:0]              grant_vec;
  logic [NUM_UNITS-1:0]              refuse_vec;
  logic [NUM_UNITS-1:0]              busy_vec;
  logic [NUM_UNITS-1:0][STAT_W-1:0]  stat_all;
  op_e                               op_all    [NUM_UNITS];
  logic [NUM_UNITS-1:0]              bcd_all;
  logic [NUM_UNITS-1:0][CNT_W-1:0]   count_all;

  assign start_try = cmd_stb & addr_ok & dec_cmd.start & ~dec_cmd.stop & ~cbusy_q;
  assign stop_try  = cmd_stb & addr_ok & dec_cmd.stop;
  assign seq_ok    = ({1'b0, seq_unit} < NUM_U);
  assign grant_any = |grant_vec;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_slot
    logic ready;
    logic end_here;

    assign sel_vec[g]    = addr_ok & (dec_unit == UNIT_W'(g));
    assign ready         = drive_attached[g] & ~busy_vec[g];
    assign grant_vec[g]  = start_try & sel_vec[g] & ready;
    assign refuse_vec[g] = start_try & sel_vec[g] & ~ready;
    assign end_here      = seq_end & seq_ok & (seq_unit == UNIT_W'(g));

    tcs_drive_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_ni),
      .stop_hit  (stop_try & sel_vec[g]),
      .grant_hit (grant_vec[g]),
      .refuse_hit(refuse_vec[g]),
      .read_hit  (status_stb & sel_vec[g]),
      .end_hit   (end_here),
      .new_op    (dec_cmd.op),
      .new_bcd   (dec_cmd.bcd),
      .new_count (dec_cmd.count),
      .end_flags (seq_flags),
      .stat_q    (stat_all[g]),
      .op_q      (op_all[g]),
      .bcd_q     (bcd_all[g]),
      .count_q   (count_all[g]),
      .disc_q    (disc_req[g]),
      .done_q    (done[g]),
      .busy      (busy_vec[g])
    );
  end

  // next state of the interlock: a grant outranks any release
  always_comb begin
    cbusy_d = cbusy_q;
    owner_d = owner_q;
    if (seq_release || (seq_end && seq_ok && (seq_unit == owner_q))) begin
      cbusy_d = 1'b0;
    end
    if (grant_any) begin
      cbusy_d = 1'b1;
      owner_d = dec_unit;
    end
  end

  assign lock_en = seq_release | seq_end | grant_any;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cbusy_q <= 1'b0;
      owner_q <= '0;
    end else if (lock_en) begin
      cbusy_q <= cbusy_d;
      owner_q <= owner_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= grant_any;
    end
  end

  // hand-off: fields come from the slot that holds the controller
  always_comb begin
    start_op    = '0;
    start_bcd   = 1'b0;
    start_count = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (owner_q == UNIT_W'(i)) begin
        start_op    = OP_W'(op_all[i]);
        start_bcd   = bcd_all[i];
        start_count = count_all[i];
      end
    end
  end

  assign ctrl_busy   = cbusy_q;
  assign start_pulse = pulse_q;
  assign start_unit  = owner_q;

  tcs_status_build #(
    .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_ni),
    .stb        (status_stb),
    .addr_ok    (addr_ok),
    .unit       (dec_unit),
    .stat_all   (stat_all),
    .ctrl_busy  (cbusy_q),
    .attached   (drive_attached),
    .wprot      (drive_wprot),
    .bot        (drive_bot),
    .eot        (drive_eot),
    .status_word(status_word)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cmd_stb && status_stb)); // R6
  AST_BUSY_DROPS_START: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_stb && cbusy_q) |=> !start_pulse); // R3
  AST_PULSE_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_ni)
    start_pulse |-> ctrl_busy); // R5
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(grant_vec)); // R1
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_ni)
    (seq_release && !grant_any) |=> !ctrl_busy); // R11
endmodule

// File: tb/tape_cmd_status_bench.sv
module tape_cmd_status_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N    = 6;
  localparam int BASE = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_stb, status_stb;
  logic [5:0]  dev_addr;
  logic [23:0] cmd_word;
  logic [N-1:0] attached, wprot, bot, eot;
  logic        seq_end;
  logic [2:0]  seq_unit;
  logic [23:0] seq_flags;
  logic        seq_release;
  logic [23:0] status_word;
  logic [N-1:0] done, disc_req;
  logic        ctrl_busy, start_pulse;
  logic [2:0]  start_unit, start_op;
  logic        start_bcd;
  logic [14:0] start_count;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tape_cmd_status #(.ADDR_W(6), .BASE_ADDR(BASE), .NUM_UNITS(N)) u_tape_cmd_status (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .status_stb(status_stb),
    .dev_addr(dev_addr), .cmd_word(cmd_word), .drive_attached(attached),
    .drive_wprot(wprot), .drive_bot(bot), .drive_eot(eot),
    .seq_end(seq_end), .seq_unit(seq_unit), .seq_flags(seq_flags),
    .seq_release(seq_release), .status_word(status_word), .done(done),
    .disc_req(disc_req), .ctrl_busy(ctrl_busy), .start_pulse(start_pulse),
    .start_unit(start_unit), .start_op(start_op), .start_bcd(start_bcd),
    .start_count(start_count)
  );

  // behavioural reference model
  logic [23:0] m_stat [N];
  logic [2:0]  m_op   [N];
  logic        m_bcd  [N];
  logic [14:0] m_cnt  [N];
  logic [N-1:0] m_done, m_disc;
  logic        m_cb;
  int          m_owner;
  logic [23:0] m_sw;
  logic        m_sp;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_stat[i] = '0; m_op[i] = '0; m_bcd[i] = 1'b0; m_cnt[i] = '0;
    end
    m_done = '0; m_disc = '0; m_cb = 1'b0; m_owner = 0; m_sw = '0; m_sp = 1'b0;
  endtask

  task automatic model_update();
    bit ok;
    int u;
    bit st, sp, gr, rf, sok;
    logic [23:0] mask;
    ok  = (dev_addr >= 6'(BASE)) && (int'(dev_addr) < BASE + N);
    u   = ok ? int'(dev_addr) - BASE : 0;
    st  = cmd_word[19];
    sp  = cmd_word[20];
    sok = int'(seq_unit) < N;
    gr  = cmd_stb && ok && st && !sp && !m_cb && attached[u] && !m_stat[u][5];
    rf  = cmd_stb && ok && st && !sp && !m_cb && !gr;
    mask = ~24'h000060;
    if (status_stb) begin
      if (ok)
        m_sw = m_stat[u] | (24'(m_cb) << 6) | (24'(!attached[u]) << 14)
             | (24'(wprot[u]) << 9) | (24'(bot[u]) << 10) | (24'(eot[u]) << 11);
      else
        m_sw = '0;
    end
    if (cmd_stb && ok && sp) m_disc[u] = 1'b1;
    if (gr) begin
      m_stat[u] = 24'h000020; m_op[u] = cmd_word[17:15]; m_bcd[u] = cmd_word[18];
      m_cnt[u] = cmd_word[14:0]; m_disc[u] = 1'b0; m_done[u] = 1'b0;
    end
    if (rf) begin
      m_stat[u][1] = 1'b1; m_done[u] = 1'b1;
    end
    if (status_stb && ok) m_done[u] = 1'b0;
    if (seq_end && sok) begin
      m_stat[seq_unit] = (m_stat[seq_unit] | (seq_flags & mask)) & ~24'h000020;
      m_disc[seq_unit] = 1'b0;
      m_done[seq_unit] = 1'b1;
    end
    if (seq_release || (seq_end && sok && int'(seq_unit) == m_owner)) m_cb = 1'b0;
    if (gr) begin m_cb = 1'b1; m_owner = u; end
    m_sp = gr;
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    check("R6 status_word", 32'(status_word), 32'(m_sw));
    check("R8 done", 32'(done), 32'(m_done));
    check("R2 disc_req", 32'(disc_req), 32'(m_disc));
    check("R5 ctrl_busy", 32'(ctrl_busy), 32'(m_cb));
    check("R1 start_pulse", 32'(start_pulse), 32'(m_sp));
    if (m_sp) begin
      check("R1 start_unit", 32'(start_unit), 32'(m_owner));
      check("R1 start_op", 32'(start_op), 32'(m_op[m_owner]));
      check("R1 start_bcd", 32'(start_bcd), 32'(m_bcd[m_owner]));
      check("R1 start_count", 32'(start_count), 32'(m_cnt[m_owner]));
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    cmd_stb = 0; status_stb = 0; seq_end = 0; seq_release = 0;
  endtask

  task automatic do_cmd(int addr, logic [23:0] w);
    dev_addr = 6'(addr); cmd_word = w; cmd_stb = 1; cycle();
  endtask

  task automatic do_stat(int addr);
    dev_addr = 6'(addr); status_stb = 1; cycle();
  endtask

  function automatic logic [23:0] start_w(int op, bit bcd, int cnt);
    return (24'h1 << 19) | (24'(bcd) << 18) | (24'(op) << 15) | 24'(cnt & 16'h7fff);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_stb = 0; status_stb = 0; dev_addr = '0; cmd_word = '0;
    attached = 6'b111011; wprot = '0; bot = '0; eot = '0;
    seq_end = 0; seq_unit = '0; seq_flags = '0; seq_release = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) cycle();
    // R12 reset state
    check("R12 status_word", 32'(status_word), 0);
    check("R12 done", 32'(done), 0);
    check("R12 ctrl_busy", 32'(ctrl_busy), 0);
    // R1 field positions and hand-off
    do_cmd(BASE + 1, start_w(5, 1, 15'h1234));
    check("R1 pulse", 32'(start_pulse), 1);
    check("R1 unit", 32'(start_unit), 1);
    check("R1 op", 32'(start_op), 5);
    check("R1 bcd", 32'(start_bcd), 1);
    check("R1 count", 32'(start_count), 32'h1234);
    check("R5 ctrl_busy set", 32'(ctrl_busy), 1);
    do_stat(BASE + 1);
    check("R5 busy only", 32'(status_word), 32'h60);
    // R3 start dropped while controller busy
    do_cmd(BASE + 2, start_w(0, 0, 3));
    check("R3 no pulse", 32'(start_pulse), 0);
    check("R3 done untouched", 32'(done[2]), 0);
    do_stat(BASE + 2);
    check("R3 R7 no attention, offline live", 32'(status_word), 32'h4040);
    // R11 early release
    seq_release = 1; cycle();
    check("R11 freed", 32'(ctrl_busy), 0);
    check("R11 done kept", 32'(done[1]), 0);
    // R4 refused starts
    do_cmd(BASE + 2, start_w(1, 0, 7));
    check("R4 unattached done", 32'(done[2]), 1);
    check("R4 no pulse", 32'(start_pulse), 0);
    do_stat(BASE + 2);
    check("R4 attention bit", 32'(status_word), 32'h4002);
    check("R8 read clears done", 32'(done[2]), 0);
    do_cmd(BASE + 1, start_w(0, 0, 1));
    check("R4 busy drive done", 32'(done[1]), 1);
    check("R4 controller stays free", 32'(ctrl_busy), 0);
    // R7 live drive conditions
    wprot[3] = 1; bot[3] = 1;
    do_stat(BASE + 3);
    check("R7 live bits", 32'(status_word), 32'h600);
    wprot[3] = 0; bot[3] = 0;
    // R2 stop wins over start
    do_cmd(BASE + 1, (24'h1 << 20) | (24'h1 << 19));
    check("R2 disc set", 32'(disc_req), 32'h2);
    check("R2 no pulse", 32'(start_pulse), 0);
    // R10 end event
    seq_end = 1; seq_unit = 3'd1; seq_flags = 24'h020061; cycle();
    check("R10 disc cleared", 32'(disc_req[1]), 0);
    check("R10 done", 32'(done[1]), 1);
    do_stat(BASE + 1);
    check("R10 merged status", 32'(status_word), 32'h020003);
    // R9 out of range
    do_stat(BASE - 1);
    check("R9 below base", 32'(status_word), 0);
    do_stat(BASE + N);
    check("R9 above range", 32'(status_word), 0);
    do_cmd(BASE + N, start_w(0, 0, 1));
    check("R9 no pulse", 32'(start_pulse), 0);
    check("R9 ctrl idle", 32'(ctrl_busy), 0);
    // R13 end and read on one drive in one cycle
    do_cmd(BASE, start_w(7, 0, 0));
    check("R1 rewind pulse", 32'(start_pulse), 1);
    dev_addr = 6'(BASE); status_stb = 1; seq_end = 1; seq_unit = 3'd0; seq_flags = 24'h1;
    cycle();
    check("R13 old status", 32'(status_word), 32'h60);
    check("R13 done set", 32'(done[0]), 1);
    check("R10 owner released", 32'(ctrl_busy), 0);
    // random traffic, compared every cycle
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 5);
      dev_addr = 6'($urandom_range(BASE - 2, BASE + N + 1));
      if (r < 2) begin
        cmd_stb = 1;
        cmd_word = {3'b000, 1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 7) != 0),
                    19'($urandom)};
      end else if (r == 2) begin
        status_stb = 1;
      end
      seq_end     = ($urandom_range(0, 7) == 0);
      seq_unit    = 3'($urandom_range(0, 7));
      seq_flags   = 24'($urandom);
      seq_release = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) attached = 6'($urandom);
      if ($urandom_range(0, 29) == 0) begin
        wprot = 6'($urandom); bot = 6'($urandom); eot = 6'($urandom);
      end
      cycle();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule